// File: doc/BRIEF.md
# Memory bit test-and-modify unit

This unit carries out the two read-modify-write bit instructions of an 8-bit accumulator processor. One sets memory bits, the other clears them. A start strobe comes with an opcode, the current accumulator and an operand address. The unit recognises four opcodes. For the other opcodes it does nothing.

After it accepts an opcode, the unit reads the target byte over a simple synchronous memory port, where read data returns one cycle after the read strobe. It forms the zero flag from the bitwise AND of that byte with the accumulator. In the last cycle of the instruction it writes back the modified byte. For the set variant this is the byte OR the accumulator. For the clear variant it is the byte AND the inverted accumulator. In that same cycle the unit raises `done` and reports the program-counter increment and the instruction's cycle count, so the surrounding core can advance.

The unit samples the accumulator and the address at the start strobe. It drives no accumulator, negative or overflow state of its own.

Top module: `bit_tmod`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr` and `zero_flag` are all 0.
- R2: The unit accepts only four opcodes: 8'h04 (set, short address), 8'h0C (set, full address), 8'h14 (clear, short address) and 8'h1C (clear, full address). A start with any other opcode leaves `busy`, `mem_rd` and `mem_wr` low.
- R3: In the `done` cycle, `zero_flag` is 1 exactly when (byte read AND accumulator) equals 0. It holds that value until the next instruction's read data arrives.
- R4: A set instruction writes back the byte read OR the accumulator.
- R5: A clear instruction writes back the byte read AND NOT the accumulator.
- R6: A short-address instruction takes 5 cycles. `done` is high in the 5th cycle after the clock edge that accepts the start, with `cycles`=5 and `pc_inc`=2. The memory address is the low 8 bits of `addr`, with the upper 8 bits forced to 0.
- R7: A full-address instruction takes 6 cycles. `done` is high in the 6th cycle, with `cycles`=6 and `pc_inc`=3. The memory address is all 16 bits of `addr`.
- R8: `mem_rd` is high for exactly one cycle, two cycles before the write. `mem_wr` is high for exactly one cycle, the last cycle of the instruction, together with `done` and at the same address as the read.
- R9: `busy` is high from the cycle after the accepting edge through the `done` cycle, and low after it. While `busy` is high, start strobes are ignored.
- R10: Changes to `acc` and `addr` after the accepting edge have no effect on the address, the flag or the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start strobe |
| opcode | input | 8 | Opcode presented with start |
| acc | input | 8 | Accumulator value |
| addr | input | 16 | Operand address (low byte only for short forms) |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final-cycle pulse |
| zero_flag | output | 1 | Zero flag from the mask test |
| pc_inc | output | 2 | Program-counter increment |
| cycles | output | 3 | Instruction cycle count |

## Verification
Random instructions use random accumulator, address and memory values. Directed cases cover a zero accumulator, disjoint and fully overlapping masks, and all-ones operands. These cases separate a zero flag taken from the pre-modify AND from one taken from the written byte. They also separate an OR from an AND-NOT write-back. Short-address operands have a non-zero high byte, which shows whether the address is zero-extended. Strobes during a running instruction carry changed accumulator and address values, which shows whether the operands are sampled once.

// File: rtl/bit_tmod.sv
module bit_tmod #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ZP_CYC  = 5,
  parameter int ABS_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          zero_flag,
  output logic [1:0]    pc_inc,
  output logic [2:0]    cycles
);
  localparam logic [2:0] ZP_N  = 3'(ZP_CYC);
  localparam logic [2:0] ABS_N = 3'(ABS_CYC);

  logic          busy_q, full_q, clr_q, z_q;
  logic [2:0]    cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] acc_q, rd_q;

  wire       legal  = (opcode[7:5] == 3'b000) && opcode[2] && (opcode[1:0] == 2'b00);
  wire       accept = start && !busy_q && legal;
  wire [2:0] last   = full_q ? ABS_N : ZP_N;

  assign busy      = busy_q;
  assign mem_addr  = addr_q;
  assign mem_rd    = busy_q && (cnt == last - 3'd2);
  assign mem_wr    = busy_q && (cnt == last);
  assign done      = mem_wr;
  assign mem_wdata = clr_q ? (rd_q & ~acc_q) : (rd_q | acc_q);
  assign zero_flag = z_q;
  assign pc_inc    = full_q ? 2'd3 : 2'd2;
  assign cycles    = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      clr_q  <= 1'b0;
      z_q    <= 1'b0;
      cnt    <= '0;
      addr_q <= '0;
      acc_q  <= '0;
      rd_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt    <= 3'd1;
      full_q <= opcode[3];
      clr_q  <= opcode[4];
      acc_q  <= acc;
      addr_q <= opcode[3] ? addr : {{(AW-8){1'b0}}, addr[7:0]};
    end else if (busy_q) begin
      cnt <= cnt + 3'd1;
      if (cnt == last - 3'd1) begin
        rd_q <= mem_rdata;
        z_q  <= ((mem_rdata & acc_q) == '0);
      end
      if (cnt == last) busy_q <= 1'b0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !mem_rd && !mem_wr);
  p_rd_before_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2) && $past(mem_addr, 2) == mem_addr);
  p_no_rd_wr_r8: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(mem_addr) && busy);
  p_zp_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pc_inc == 2'd2 |-> mem_addr[AW-1:8] == '0);
endmodule

// File: tb/bit_tmod_test.sv
module bit_tmod_test;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  opcode = 0, acc = 0;
  logic [15:0] addr = 0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, busy, done, zero_flag;
  logic [7:0]  mem_rdata, mem_wdata;
  logic [1:0]  pc_inc;
  logic [2:0]  cycles;
  logic [7:0]  mem [int];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bit_tmod uut (.clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
    .addr(addr), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .zero_flag(zero_flag), .pc_inc(pc_inc), .cycles(cycles));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_wr(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m);
    return op[4] ? (m & ~a) : (m | a);
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [15:0] ad,
                        input logic [7:0] m, input bit disturb);
    logic [15:0] eff = op[3] ? ad : {8'h00, ad[7:0]};
    int last = op[3] ? 6 : 5;
    logic [7:0] ew = exp_wr(op, a, m);
    mem[int'(eff)] = m;
    @(negedge clk);
    start = 1; opcode = op; acc = a; addr = ad;
    @(negedge clk);
    start = 0;
    for (int n = 1; n <= last; n++) begin
      if (disturb && n == 2) begin
        start = 1; opcode = 8'h0C; acc = ~a; addr = ad ^ 16'h5A5A;
      end
      if (disturb && n == 3) start = 0;
      chk(busy == 1'b1, "R9 busy", busy, 1);
      chk(mem_rd == (n == last - 2), op[3] ? "R8/R7 rd timing" : "R8/R6 rd timing", mem_rd, n == last - 2);
      chk(mem_wr == (n == last) && done == (n == last), "R8 wr/done timing", {mem_wr, done}, n == last ? 3 : 0);
      if (n == last - 2) chk(mem_addr == eff, op[3] ? "R7 address" : "R6 address", mem_addr, eff);
      if (n == last) begin
        chk(mem_addr == eff, "R8/R10 write address", mem_addr, eff);
        chk(mem_wdata == ew, op[4] ? "R5 clear data" : "R4 set data", mem_wdata, ew);
        chk(zero_flag == ((m & a) == 0), "R3 zero flag", zero_flag, (m & a) == 0);
        chk(pc_inc == (op[3] ? 2'd3 : 2'd2) && cycles == 3'(last),
            op[3] ? "R7 len/cycles" : "R6 len/cycles", {pc_inc, 1'b0, cycles}, {op[3] ? 2'd3 : 2'd2, 1'b0, 3'(last)});
      end
      @(negedge clk);
    end
    chk(busy == 1'b0 && !mem_rd && !mem_wr, "R9 idle after done", busy, 0);
    chk(mem[int'(eff)] == ew, op[4] ? "R5 memory" : "R4 memory", mem[int'(eff)], ew);
    chk(zero_flag == ((m & a) == 0), "R3 flag held", zero_flag, (m & a) == 0);
  endtask

  initial begin
    logic [7:0] ops [4] = '{8'h04, 8'h0C, 8'h14, 8'h1C};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && !zero_flag, "R1 reset state",
        {busy, done, mem_rd, mem_wr, zero_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && !zero_flag, "R1 after release",
        {busy, done, mem_rd, mem_wr, zero_flag}, 0);

    foreach (ops[i]) begin
      run_op(ops[i], 8'h00, 16'h12F0, 8'hA5, 0);
      run_op(ops[i], 8'h0F, 16'hAB34, 8'hF0, 0);
      run_op(ops[i], 8'hFF, 16'h00FF, 8'hFF, 0);
      run_op(ops[i], 8'h81, 16'hFFFF, 8'h01, 0);
    end
    run_op(8'h04, 8'h3C, 16'h7710, 8'h42, 1);
    run_op(8'h1C, 8'hC3, 16'h2345, 8'h99, 1);

    foreach (ops[i]) if (i == 0) begin
      logic [7:0] bad [6] = '{8'h05, 8'h00, 8'h24, 8'h0D, 8'h84, 8'h1E};
      foreach (bad[j]) begin
        @(negedge clk);
        start = 1; opcode = bad[j]; acc = 8'hFF; addr = 16'h0040;
        @(negedge clk);
        start = 0;
        repeat (3) begin
          chk(!busy && !mem_rd && !mem_wr, "R2 unknown opcode ignored", {busy, mem_rd, mem_wr}, 0);
          @(negedge clk);
        end
      end
    end

    for (int k = 0; k < 60; k++)
      run_op(ops[$urandom_range(3)], 8'($urandom), 16'($urandom), 8'($urandom), ($urandom_range(4) == 0));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule